// File: doc/BRIEF.md
# I2C Bit-Clock Timing Generator

This block produces the clock line and the bit strobes for an I2C master. It runs from a fixed 24 MHz reference. Two timing words set the lengths of the clock's released and driven halves, and a point inside each half. In the high half, a sample strobe tells the byte engine when to read SDA. In the low half, a change strobe tells it when to put the next SDA value out. A third word sets the setup and hold time around start and stop conditions, and the idle gap after a stop.

The byte engine begins a transaction with a start request. The generator then waits for the setup time with SCL high and pulses a start strobe, which is when the engine pulls SDA low. After the hold time it begins clocking bits. It keeps clocking until a stop request has been recorded. At the end of the next low half it releases SCL and waits the setup time. It then pulses a stop strobe and keeps the bus free for the programmed gap.

The clock output is an open-drain "drive low" control. The pin level is read back through a synchronizer, so a slave that holds SCL low stretches the high half. Deriving the counts from a bus speed is left to software. A typical rule is base = (24 MHz / f − 38) / 2, with high = base + 3, low = base − 3, sample = 3/4 of high and change = 1/4 of low. Sensible rates lie between about 12 kHz and 540 kHz.

Top module: `scl_timing_gen`

## Requirements
- R1: While `rst` is high and after it falls, `scl_drive_low` and all four strobes are 0 and the generator is idle.
- R2: The timing words are laid out as follows. `hi_word[31:16]` is the high-half length and `hi_word[15:0]` the sample point. `lo_word[31:16]` is the low-half length and `lo_word[15:0]` the change point. `cond_word[31:16]` is the start/stop setup-and-hold length and `cond_word[15:0]` the bus-free length. With high 104, sample 78, low 98 and change 24 (100 kHz) and `cond_word` = 0x00300030, each low half lasts 98 cycles.
- R3: A `start_req` in idle starts the start sequence. The generator counts setup cycles while the synchronized SCL is high, then pulses `start_stb` for one cycle. It then holds SCL released for the same count before driving it low.
- R4: Each low half drives `scl_drive_low` for exactly the low length in cycles, where a length of 0 acts as 1. `change_stb` fires once per low half, when the count (0 in the first low cycle) equals the change point.
- R5: In the high half SCL is released. The count advances only in cycles where the pin, seen through `SYNC_STAGES` flops (default 2), is high. Without stretching, the released time is high length + `SYNC_STAGES` cycles.
- R6: `sample_stb` fires exactly once per high half, in the advancing cycle whose count equals the sample point. It does not fire at all if the sample point is at or beyond the high length.
- R7: While a slave holds SCL low during a high half, the count freezes, no sample strobe occurs and SCL stays released.
- R8: The low fields are captured when a low half begins, and the high fields when a high half begins. Writing a word mid-half changes only the next half of that kind.
- R9: A `stop_req` recorded during start or bit clocking takes effect at the end of the next low half. SCL is released, setup cycles are counted while SCL is high, `stop_stb` pulses once, and the block stays busy for the bus-free length before returning to idle.
- R10: `stop_req` in idle and `start_req` outside idle have no effect.
- R11: Each strobe is a one-cycle pulse, and no two strobes are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_word | input | 32 | High length [31:16], sample point [15:0] |
| lo_word | input | 32 | Low length [31:16], change point [15:0] |
| cond_word | input | 32 | Start/stop setup length [31:16], bus-free length [15:0] |
| start_req | input | 1 | Begin a transaction (idle only) |
| stop_req | input | 1 | End the transaction after the next low half |
| scl_in | input | 1 | SCL level read from the pin |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sample_stb | output | 1 | Read SDA now |
| change_stb | output | 1 | Update SDA now |
| start_stb | output | 1 | Pull SDA low for a start condition |
| stop_stb | output | 1 | Release SDA for a stop condition |

## Verification
The hardest case to reach is a clock stretch that begins exactly as a high half starts, before the released level has passed through the synchronizer. A stretch that arrives later lets a sample strobe slip out first. The stimulus therefore follows the reference model's phase. In the first cycle of a high half it pulls the modelled pin low, holds it for a dozen cycles and then lets go. A second hard case is a timing word rewritten in the first cycle of a low half. The bench then checks that the current low keeps its old length and the following one takes the new length.

// File: rtl/sclt_pkg.sv
package sclt_pkg;
  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_START_SU = 3'd1,
    PH_START_HD = 3'd2,
    PH_LOW      = 3'd3,
    PH_HIGH     = 3'd4,
    PH_STOP_SU  = 3'd5,
    PH_FREE     = 3'd6
  } sclt_phase_e;
endpackage

// File: rtl/sclt_sync.sv
module sclt_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sclt_cnt.sv
module sclt_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] len,
  output logic [W-1:0] cnt,
  output logic         last
);
  logic [W:0] len_eff;
  logic [W:0] cnt_ext;

  // A zero length behaves as a single cycle.
  assign len_eff = (len == '0) ? (W+1)'(1) : {1'b0, len};
  assign cnt_ext = {1'b0, cnt};
  assign last    = adv && ((cnt_ext + (W+1)'(1)) >= len_eff);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (adv)    cnt <= cnt + W'(1);
  end

  // R4 / R5: the count never reaches the length of the current phase
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_ext < len_eff);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import sclt_pkg::*;
#(
  parameter  int CNT_W       = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int WORD_W      = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] cond_word,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              scl_in,
  output logic              scl_drive_low,
  output logic              sample_stb,
  output logic              change_stb,
  output logic              start_stb,
  output logic              stop_stb
);
  sclt_phase_e st_q, st_d;

  logic [CNT_W-1:0] hi_len_q, hi_smp_q, lo_len_q, lo_chg_q, su_len_q, free_len_q;
  logic             stop_pend_q;
  logic             scl_hi_s;
  logic [CNT_W-1:0] cnt, cur_len;
  logic             cnt_adv, cnt_clr, cnt_last;
  logic             smp_c, chg_c, sst_c, spt_c, stop_ok;

  sclt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (scl_in),
    .q   (scl_hi_s)
  );

  sclt_cnt #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (cnt_clr),
    .adv  (cnt_adv),
    .len  (cur_len),
    .cnt  (cnt),
    .last (cnt_last)
  );

  // Counting rule and length of each phase
  always_comb begin
    cnt_adv = 1'b0;
    cur_len = '0;
    unique case (st_q)
      PH_START_SU: begin cnt_adv = scl_hi_s; cur_len = su_len_q;   end
      PH_START_HD: begin cnt_adv = 1'b1;     cur_len = su_len_q;   end
      PH_LOW:      begin cnt_adv = 1'b1;     cur_len = lo_len_q;   end
      PH_HIGH:     begin cnt_adv = scl_hi_s; cur_len = hi_len_q;   end
      PH_STOP_SU:  begin cnt_adv = scl_hi_s; cur_len = su_len_q;   end
      PH_FREE:     begin cnt_adv = 1'b1;     cur_len = free_len_q; end
      default:     begin cnt_adv = 1'b0;     cur_len = '0;         end
    endcase
  end

  // Phase sequencing
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PH_IDLE:     if (start_req) st_d = PH_START_SU;
      PH_START_SU: if (cnt_last)  st_d = PH_START_HD;
      PH_START_HD: if (cnt_last)  st_d = PH_LOW;
      PH_LOW:      if (cnt_last)  st_d = stop_pend_q ? PH_STOP_SU : PH_HIGH;
      PH_HIGH:     if (cnt_last)  st_d = PH_LOW;
      PH_STOP_SU:  if (cnt_last)  st_d = PH_FREE;
      PH_FREE:     if (cnt_last)  st_d = PH_IDLE;
      default:                    st_d = PH_IDLE;
    endcase
  end

  assign cnt_clr = (st_d != st_q) || (st_q == PH_IDLE);
  assign smp_c   = (st_q == PH_HIGH) && scl_hi_s && (cnt == hi_smp_q);
  assign chg_c   = (st_q == PH_LOW) && (cnt == lo_chg_q);
  assign sst_c   = (st_q == PH_START_SU) && cnt_last;
  assign spt_c   = (st_q == PH_STOP_SU) && cnt_last;
  assign stop_ok = stop_req && (st_q inside {PH_START_SU, PH_START_HD, PH_LOW, PH_HIGH});

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= PH_IDLE;
      hi_len_q      <= '0;
      hi_smp_q      <= '0;
      lo_len_q      <= '0;
      lo_chg_q      <= '0;
      su_len_q      <= '0;
      free_len_q    <= '0;
      stop_pend_q   <= 1'b0;
      scl_drive_low <= 1'b0;
      sample_stb    <= 1'b0;
      change_stb    <= 1'b0;
      start_stb     <= 1'b0;
      stop_stb      <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == PH_IDLE && st_d == PH_START_SU) begin
        su_len_q   <= cond_word[WORD_W-1:CNT_W];
        free_len_q <= cond_word[CNT_W-1:0];
      end
      if (st_d == PH_LOW && st_q != PH_LOW) begin
        lo_len_q <= lo_word[WORD_W-1:CNT_W];
        lo_chg_q <= lo_word[CNT_W-1:0];
      end
      if (st_d == PH_HIGH && st_q != PH_HIGH) begin
        hi_len_q <= hi_word[WORD_W-1:CNT_W];
        hi_smp_q <= hi_word[CNT_W-1:0];
      end
      if (st_q == PH_LOW && st_d == PH_STOP_SU) stop_pend_q <= 1'b0;
      else                                        stop_pend_q <= stop_pend_q | stop_ok;
      scl_drive_low <= (st_d == PH_LOW);
      sample_stb    <= smp_c;
      change_stb    <= chg_c;
      start_stb     <= sst_c;
      stop_stb      <= spt_c;
    end
  end

  // R11: at most one strobe per cycle
  a_r11_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $countones({sample_stb, change_stb, start_stb, stop_stb}) <= 1);

  // R6: sampling happens in a cycle where SCL was released
  a_r6_sample_released: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> !$past(scl_drive_low));

  // R4: the change strobe belongs to a driven-low cycle
  a_r4_change_in_low: assert property (@(posedge clk) disable iff (rst)
    change_stb |-> $past(scl_drive_low));

  // R7: a held-low pin freezes the high count
  a_r7_stretch_freeze: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_HIGH && !scl_hi_s) |=> $stable(cnt));

  // R8: no reload inside a low half
  a_r8_low_fields_hold: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_LOW && $past(st_q) == PH_LOW) |-> $stable(lo_len_q) && $stable(lo_chg_q));

  // R9: the stop setup is entered only from a low half
  a_r9_stop_after_low: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_STOP_SU && $past(st_q) != PH_STOP_SU) |-> $past(st_q) == PH_LOW);

  // R3: the start setup is entered only from idle
  a_r3_start_from_idle: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_START_SU && $past(st_q) != PH_START_SU) |-> $past(st_q) == PH_IDLE);

  // R10: no stop is left pending while idle
  a_r10_idle_no_pend: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_IDLE) |-> !stop_pend_q);
endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] hi_word = '0, lo_word = '0, cond_word = '0;
  logic        start_req = 1'b0, stop_req = 1'b0, hold = 1'b0;
  logic        scl_in;
  logic        scl_drive_low, sample_stb, change_stb, start_stb, stop_stb;

  always #5 clk = ~clk;
  assign scl_in = !scl_drive_low && !hold;

  scl_timing_gen #(.CNT_W(16), .SYNC_STAGES(SYNC)) u_scl_timing_gen (
    .clk(clk), .rst(rst), .hi_word(hi_word), .lo_word(lo_word), .cond_word(cond_word),
    .start_req(start_req), .stop_req(stop_req), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .sample_stb(sample_stb), .change_stb(change_stb),
    .start_stb(start_stb), .stop_stb(stop_stb));

  // Reference model state (phases: 0 idle,1 start setup,2 start hold,3 low,4 high,5 stop setup,6 free)
  int m_st, m_cnt, m_hl, m_hs, m_ll, m_lc, m_sl, m_fl, m_nsmp, prev_st;
  bit m_pend;
  bit m_sy [SYNC];
  bit e_drv, e_smp, e_chg, e_sst, e_spt;

  int checks = 0, errors = 0, cyc = 0;
  int n_smp = 0, n_chg = 0, n_sst = 0, n_spt = 0, n_multi = 0;
  int low_run = 0, rel_run = 0;
  bit seen_low = 0;
  int low_q[$], rel_q[$];
  string req_tag = "R1";

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit shi, line, adv, last, stop_ok;
    int len, leff, nst;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_hl = 0; m_hs = 0; m_ll = 0; m_lc = 0; m_sl = 0; m_fl = 0;
      m_pend = 0;
      for (int i = 0; i < SYNC; i++) m_sy[i] = 1'b1;
      e_drv = 0; e_smp = 0; e_chg = 0; e_sst = 0; e_spt = 0;
      return;
    end
    shi  = m_sy[SYNC-1];
    line = !e_drv && !hold;
    case (m_st)
      1: begin adv = shi;  len = m_sl; end
      2: begin adv = 1'b1; len = m_sl; end
      3: begin adv = 1'b1; len = m_ll; end
      4: begin adv = shi;  len = m_hl; end
      5: begin adv = shi;  len = m_sl; end
      6: begin adv = 1'b1; len = m_fl; end
      default: begin adv = 1'b0; len = 0; end
    endcase
    leff = (len == 0) ? 1 : len;
    last = adv && (m_cnt + 1 >= leff);
    nst = m_st;
    case (m_st)
      0: if (start_req) nst = 1;
      1: if (last) nst = 2;
      2: if (last) nst = 3;
      3: if (last) nst = m_pend ? 5 : 4;
      4: if (last) nst = 3;
      5: if (last) nst = 6;
      6: if (last) nst = 0;
      default: nst = 0;
    endcase
    e_smp = (m_st == 4) && shi && (m_cnt == m_hs);
    e_chg = (m_st == 3) && (m_cnt == m_lc);
    e_sst = (m_st == 1) && last;
    e_spt = (m_st == 5) && last;
    if (e_smp) m_nsmp++;
    stop_ok = stop_req && (m_st >= 1) && (m_st <= 4);
    if (m_st == 0 && nst == 1) begin m_sl = int'(cond_word[31:16]); m_fl = int'(cond_word[15:0]); end
    if (nst == 3 && m_st != 3) begin m_ll = int'(lo_word[31:16]); m_lc = int'(lo_word[15:0]); end
    if (nst == 4 && m_st != 4) begin m_hl = int'(hi_word[31:16]); m_hs = int'(hi_word[15:0]); end
    m_pend = (m_st == 3 && nst == 5) ? 1'b0 : (m_pend || stop_ok);
    m_cnt  = (nst != m_st || m_st == 0) ? 0 : (adv ? m_cnt + 1 : m_cnt);
    for (int i = SYNC - 1; i > 0; i--) m_sy[i] = m_sy[i-1];
    m_sy[0] = line;
    e_drv = (nst == 3);
    prev_st = m_st;
    m_st = nst;
  endtask

  task automatic tick();
    model_edge();
    @(posedge clk);
    #1;
    cyc++;
    checks++;
    if ({scl_drive_low, sample_stb, change_stb, start_stb, stop_stb} !==
        {e_drv, e_smp, e_chg, e_sst, e_spt}) begin
      errors++;
      $display("FAIL %s cycle %0d actual=%b expected=%b", req_tag, cyc,
               {scl_drive_low, sample_stb, change_stb, start_stb, stop_stb},
               {e_drv, e_smp, e_chg, e_sst, e_spt});
    end
    if (sample_stb) n_smp++;
    if (change_stb) n_chg++;
    if (start_stb)  n_sst++;
    if (stop_stb)   n_spt++;
    if (32'($countones({sample_stb, change_stb, start_stb, stop_stb})) > 1) n_multi++;
    if (scl_drive_low) begin
      if (rel_run > 0 && seen_low) rel_q.push_back(rel_run);
      rel_run = 0; low_run++; seen_low = 1;
    end else begin
      if (low_run > 0) low_q.push_back(low_run);
      low_run = 0;
      if (seen_low) rel_run++;
    end
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog cycle %0d actual=hung expected=done", cyc);
      finish_run();
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    int base;
    // R1: reset
    rst = 1'b1;
    run(3);
    rst = 1'b0;
    run(2);
    chk({scl_drive_low, sample_stb, change_stb, start_stb, stop_stb} == 5'b0, "R1 idle after reset",
        int'({scl_drive_low, sample_stb, change_stb, start_stb, stop_stb}), 0);

    // R10: stop in idle is ignored
    req_tag = "R10";
    stop_req = 1'b1; tick(); stop_req = 1'b0;
    run(6);
    chk(scl_drive_low == 1'b0 && n_spt == 0, "R10 stop in idle", n_spt, 0);

    // R3: start sequence with small counts
    req_tag = "R3";
    hi_word = {16'd6, 16'd3}; lo_word = {16'd5, 16'd1}; cond_word = {16'd4, 16'd3};
    start_req = 1'b1; tick(); start_req = 1'b0;
    run(15);
    chk(n_sst == 1, "R3 one start strobe", n_sst, 1);

    // R5 / R6 / R4: steady clocking
    req_tag = "R5";
    n_smp = 0; m_nsmp = 0; low_q.delete(); rel_q.delete();
    run(60);
    chk(n_smp == m_nsmp && n_smp > 0, "R6 one sample per high", n_smp, m_nsmp);
    chk(rel_q.size() > 0 && rel_q[$] == 6 + SYNC, "R5 released time",
        rel_q.size() > 0 ? rel_q[$] : -1, 6 + SYNC);
    chk(low_q.size() > 0 && low_q[$] == 5, "R4 low width", low_q.size() > 0 ? low_q[$] : -1, 5);

    // R10: start requests while busy
    req_tag = "R10";
    base = n_sst;
    for (int i = 0; i < 20; i++) begin
      start_req = (i % 3 == 0); tick();
    end
    start_req = 1'b0;
    chk(n_sst == base, "R10 start while busy", n_sst, base);

    // R7: stretch from the first cycle of a high half
    req_tag = "R7";
    do tick(); while (!(m_st == 4 && prev_st == 3));
    base = n_smp;
    hold = 1'b1;
    run(12);
    chk(n_smp == base, "R7 no sample while held", n_smp, base);
    chk(scl_drive_low == 1'b0, "R7 SCL stays released", int'(scl_drive_low), 0);
    hold = 1'b0;
    run(30);

    // R8: rewrite words in the first cycle of a low half
    req_tag = "R8";
    do tick(); while (!(m_st == 3 && prev_st != 3));
    lo_word = {16'd9, 16'd2}; hi_word = {16'd8, 16'd5};
    low_q.delete();
    run(45);
    chk(low_q.size() >= 2 && low_q[0] == 5, "R8 current low keeps old length",
        low_q.size() > 0 ? low_q[0] : -1, 5);
    chk(low_q.size() >= 2 && low_q[1] == 9, "R8 next low takes new length",
        low_q.size() > 1 ? low_q[1] : -1, 9);

    // R6: sample point beyond the high length
    req_tag = "R6";
    hi_word = {16'd4, 16'd7};
    run(30);
    n_smp = 0;
    run(40);
    chk(n_smp == 0, "R6 sample point out of range", n_smp, 0);

    // R4: zero low length and zero change point
    req_tag = "R4";
    lo_word = {16'd0, 16'd0}; hi_word = {16'd3, 16'd0};
    run(30);
    low_q.delete(); n_chg = 0;
    run(30);
    chk(low_q.size() > 0 && low_q[$] == 1, "R4 zero length acts as one",
        low_q.size() > 0 ? low_q[$] : -1, 1);
    chk(n_chg == low_q.size() || n_chg == low_q.size() + 1, "R4 change each low",
        n_chg, low_q.size());

    // R9: stop sequence, start ignored during bus-free time
    req_tag = "R9";
    lo_word = {16'd5, 16'd1}; hi_word = {16'd6, 16'd3};
    base = n_spt;
    stop_req = 1'b1; tick(); stop_req = 1'b0;
    do tick(); while (m_st != 6);
    chk(n_spt == base + 1, "R9 one stop strobe", n_spt, base + 1);
    base = n_sst;
    start_req = 1'b1; tick(); start_req = 1'b0;
    do tick(); while (m_st != 0);
    run(4);
    chk(n_sst == base && scl_drive_low == 1'b0, "R9 bus free then idle", n_sst, base);

    // R2: real 100 kHz counts
    req_tag = "R2";
    hi_word = {16'd104, 16'd78}; lo_word = {16'd98, 16'd24}; cond_word = 32'h0030_0030;
    low_q.delete();
    start_req = 1'b1; tick(); start_req = 1'b0;
    do tick(); while (low_q.size() < 2);
    chk(low_q[0] == 98 && low_q[1] == 98, "R2 low width at 100 kHz", low_q[1], 98);
    stop_req = 1'b1; tick(); stop_req = 1'b0;
    do tick(); while (m_st != 0);
    run(3);

    chk(n_multi == 0, "R11 single strobe per cycle", n_multi, 0);
    finish_run();
  end
endmodule